// File: doc/BRIEF.md
# Cubic Spline Knot Interpolator

This block turns a queue of polynomial spline knots into a stream of waveform samples. A knot carries an integer duration and starting values for a chain of four accumulators, the constant term through the cubic term. On every evaluation step each accumulator adds the value held by the accumulator of the next higher order. The output therefore follows a cubic polynomial without any multiplier. When a knot's duration has run out, the next queued knot takes its place on that same step.

The evaluation rate is the enabled tick rate divided by a programmable power of two, so slow sweeps can use sparse knots. Phase-like channels load only the constant term. Frequency-like channels load the constant and linear terms. If the knot queue runs dry, the waveform freezes and a flag reports the underrun until a new knot arrives.

Top module: `spline_knot_interp`

## Requirements
- R1: After reset `sample_out` is 0, `underrun` is 0 and `knot_ready` is 1.
- R2: On a step, every accumulator n below the highest order becomes its old value plus the old value of accumulator n+1, all at once. The highest order keeps its value. `sample_out` is the top 16 bits of the constant-term accumulator, so a knot with a cubic term of 6 and all other terms 0 shows 0, 0, 0, 6, 24 on successive steps.
- R3: All accumulators are 64 bits wide. `knot_coef` packs term 0 in bits 15:0, term 1 in bits 47:16, term 2 in bits 95:48 and term 3 in bits 159:96. Each term is loaded left-aligned in its 64-bit accumulator, with the lower bits cleared. A term-1 field of 32'h0005_0000 therefore adds 5 to `sample_out` per step.
- R4: A knot with duration T covers T steps: it shows its starting value and then T-1 advanced values. A duration of 0 is handled as 1.
- R5: A step occurs on a cycle with `tick_en` high once a prescale count has reached 2^`stretch_exp`-1. The count then restarts from 0. The count advances by one on other enabled ticks and is cleared whenever a knot is loaded.
- R6: While a knot is running, `knot_ready` is high only in the cycle of its final step. A knot presented there is loaded in place of that step, with no gap sample. Loading clears `underrun`.
- R7: If no knot is offered at the final step, every accumulator holds its value and `underrun` goes to 1. While no knot is running, `knot_ready` is 1 and an offered knot loads at the next clock edge, whatever `tick_en` is.
- R8: A knot whose higher terms are zero gives a constant output (term 0 only) or a straight ramp (terms 0 and 1 only).
- R9: In a cycle with `tick_en` low and no knot loaded, `sample_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Update tick enable |
| stretch_exp | input | 4 | Time-stretch exponent E, steps every 2^E ticks |
| knot_valid | input | 1 | Knot offered |
| knot_ready | output | 1 | Knot accepted this cycle when valid |
| knot_dur | input | 16 | Knot duration in steps |
| knot_coef | input | 160 | Packed starting values of terms 0..3 |
| sample_out | output | 16 | Current waveform sample |
| underrun | output | 1 | Queue ran dry at knot expiry |

## Verification
The properties assume that a knot is offered on a valid/ready handshake. They also assume that `knot_dur`, `knot_coef` and `stretch_exp` carry known values whenever they are sampled. No ordering between `tick_en` and `knot_valid` is assumed. The stimulus drives every input with defined values from reset onward. Inputs change only between clock edges, and the stretch exponent is switched in the middle of running knots, so the prescale rule is exercised both when the count is below the new limit and when it is above it.

// File: rtl/spline_pkg.sv
package spline_pkg;
    localparam int DEF_OUT_W = 16;
    localparam int DEF_ORDER = 3;
    localparam int DEF_DUR_W = 16;
    localparam int DEF_EXP_W = 4;

    // Bit offset of term n in the packed coefficient bus (term n is out_w*(n+1) wide)
    function automatic int coef_offset(input int n, input int out_w);
        return out_w * n * (n + 1) / 2;
    endfunction

    function automatic int coef_bus_width(input int order, input int out_w);
        return out_w * (order + 1) * (order + 2) / 2;
    endfunction
endpackage

// File: rtl/spline_prescaler.sv
module spline_prescaler #(
    parameter int EXP_W = 4,
    localparam int PRE_W = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [EXP_W-1:0] stretch_exp,
    input  logic             clear,
    output logic             step
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t             pre_d, pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = ~({PRE_W{1'b1}} << stretch_exp);
        step  = tick_en && (pre_q.cnt >= limit);
        pre_d = pre_q;
        if (clear) begin
            pre_d.cnt = '0;
        end else if (tick_en) begin
            pre_d.cnt = step ? '0 : pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/spline_acc_chain.sv
module spline_acc_chain
    import spline_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W,
    parameter int ORDER = DEF_ORDER,
    localparam int ACC_W  = OUT_W * (ORDER + 1),
    localparam int COEF_W = coef_bus_width(ORDER, OUT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [COEF_W-1:0] knot_coef,
    output logic [OUT_W-1:0]  sample
);
    typedef struct packed {
        logic [ORDER:0][ACC_W-1:0] acc;
    } chain_t;

    chain_t                    ch_d, ch_q;
    logic [ORDER:0][ACC_W-1:0] seed;

    for (genvar g = 0; g <= ORDER; g++) begin : g_seed
        localparam int FW  = OUT_W * (g + 1);
        localparam int OFF = coef_offset(g, OUT_W);
        assign seed[g] = ACC_W'(knot_coef[OFF +: FW]) << (ACC_W - FW);
    end

    always_comb begin
        ch_d = ch_q;
        if (load) begin
            ch_d.acc = seed;
        end else if (advance) begin
            for (int n = 0; n < ORDER; n++) begin
                ch_d.acc[n] = ch_q.acc[n] + ch_q.acc[n+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign sample = ch_q.acc[0][ACC_W-1 -: OUT_W];
endmodule

// File: rtl/spline_knot_interp.sv
module spline_knot_interp
    import spline_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W,
    parameter int ORDER = DEF_ORDER,
    parameter int DUR_W = DEF_DUR_W,
    parameter int EXP_W = DEF_EXP_W,
    localparam int COEF_W = coef_bus_width(ORDER, OUT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [EXP_W-1:0]  stretch_exp,
    input  logic              knot_valid,
    output logic              knot_ready,
    input  logic [DUR_W-1:0]  knot_dur,
    input  logic [COEF_W-1:0] knot_coef,
    output logic [OUT_W-1:0]  sample_out,
    output logic              underrun
);
    typedef struct packed {
        logic             active;
        logic             underrun;
        logic [DUR_W-1:0] rem;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic step, expire, load, advance;

    spline_prescaler #(.EXP_W(EXP_W)) i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .stretch_exp(stretch_exp),
        .clear      (load),
        .step       (step)
    );

    always_comb begin
        expire     = ctl_q.active && step && (ctl_q.rem == DUR_W'(1));
        knot_ready = !ctl_q.active || expire;
        load       = knot_valid && knot_ready;
        advance    = ctl_q.active && step && !expire;
        ctl_d      = ctl_q;
        if (load) begin
            ctl_d.active   = 1'b1;
            ctl_d.underrun = 1'b0;
            ctl_d.rem      = (knot_dur == '0) ? DUR_W'(1) : knot_dur;
        end else if (expire) begin
            ctl_d.active   = 1'b0;
            ctl_d.underrun = 1'b1;
        end else if (advance) begin
            ctl_d.rem = ctl_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    spline_acc_chain #(.OUT_W(OUT_W), .ORDER(ORDER)) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .knot_coef(knot_coef),
        .sample   (sample_out)
    );

    assign underrun = ctl_q.underrun;
endmodule

// File: rtl/spline_knot_interp_chk.sv
module spline_knot_interp_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             knot_valid,
    input logic             knot_ready,
    input logic [OUT_W-1:0] sample_out,
    input logic             underrun
);
    // R9: no tick and no load leaves the sample unchanged
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(knot_valid && knot_ready)) |=> $stable(sample_out));

    // R7: starved state freezes output and keeps the flag
    a_r7_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !knot_valid) |=> ($stable(sample_out) && underrun));

    // R7: a starved block accepts a knot at once
    a_r7_ready_when_starved: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> knot_ready);

    // R6: a load clears the underrun flag
    a_r6_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (knot_valid && knot_ready) |=> !underrun);

    // R6: a running knot only frees the input on a tick
    a_r6_ready_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (knot_ready && !tick_en && !underrun && $past(knot_valid && knot_ready)) |-> 1'b0);
endmodule

bind spline_knot_interp spline_knot_interp_chk #(.OUT_W(OUT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .knot_valid(knot_valid),
    .knot_ready(knot_ready),
    .sample_out(sample_out),
    .underrun  (underrun)
);

// File: tb/test_spline_knot_interp.sv
module test_spline_knot_interp;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [3:0]   stretch_exp = '0;
    logic         knot_valid = 1'b0;
    logic         knot_ready;
    logic [15:0]  knot_dur = '0;
    logic [159:0] knot_coef = '0;
    logic [15:0]  sample_out;
    logic         underrun;

    int n_checks = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [63:0] m_acc [4];
    bit          m_active = 0;
    bit          m_under = 0;
    int          m_rem = 0;
    int          m_cnt = 0;
    bit          m_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    spline_knot_interp i_spline_knot_interp (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stretch_exp(stretch_exp),
        .knot_valid(knot_valid), .knot_ready(knot_ready), .knot_dur(knot_dur),
        .knot_coef(knot_coef), .sample_out(sample_out), .underrun(underrun)
    );

    function automatic logic [159:0] mk(input logic [15:0] t0, input logic [31:0] t1,
                                        input logic [47:0] t2, input logic [63:0] t3);
        return {t3, t2, t1, t0};   // R3 packing
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input bit v, input logic [15:0] d, input logic [159:0] c,
                       input bit t, input logic [3:0] e, output bit accepted);
        int  lim;
        bit  stp, exp_now, ld;
        logic [63:0] old [4];
        knot_valid = v; knot_dur = d; knot_coef = c; tick_en = t; stretch_exp = e;
        #1;
        lim     = (1 << e) - 1;
        stp     = t && (m_cnt >= lim);
        exp_now = m_active && stp && (m_rem == 1);
        m_ready = !m_active || exp_now;
        ld      = v && m_ready;
        chk("R6 knot_ready", 64'(knot_ready), 64'(m_ready));
        for (int i = 0; i < 4; i++) old[i] = m_acc[i];
        if (ld) begin
            m_acc[0] = {c[15:0], 48'h0};
            m_acc[1] = {c[47:16], 32'h0};
            m_acc[2] = {c[95:48], 16'h0};
            m_acc[3] = c[159:96];
            m_active = 1; m_under = 0; m_rem = (d == 0) ? 1 : int'(d);
        end else if (exp_now) begin
            m_active = 0; m_under = 1;
        end else if (m_active && stp) begin
            for (int i = 0; i < 3; i++) m_acc[i] = old[i] + old[i+1];
            m_rem--;
        end
        if (ld) m_cnt = 0;
        else if (t) m_cnt = stp ? 0 : m_cnt + 1;
        accepted = ld;
        @(negedge clk);
        chk("R2 R4 R5 sample_out vs model", 64'(sample_out), 64'(m_acc[0][63:48]));
        chk("R7 underrun vs model", 64'(underrun), 64'(m_under));
    endtask

    task automatic idle(input int n, input bit t, input logic [3:0] e);
        bit a;
        for (int i = 0; i < n; i++) run(0, 16'd0, '0, t, e, a);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit a;
        logic [159:0] lin;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset sample_out", 64'(sample_out), 64'h0);
        chk("R1 reset underrun", 64'(underrun), 64'h0);
        chk("R1 reset knot_ready", 64'(knot_ready), 64'h1);
        @(negedge clk);

        // R8 constant knot, T=3
        run(1, 16'd3, mk(16'h1234, 0, 0, 0), 1, 4'd0, a);
        idle(2, 1, 4'd0);
        chk("R8 constant output", 64'(sample_out), 64'h1234);
        idle(2, 1, 4'd0);
        chk("R7 underrun set after expiry", 64'(underrun), 64'h1);
        chk("R7 output frozen", 64'(sample_out), 64'h1234);

        // R8 linear ramp, slope 5, T=10
        lin = mk(16'd100, 32'h0005_0000, 0, 0);
        run(1, 16'd10, lin, 1, 4'd0, a);
        idle(2, 1, 4'd0);
        chk("R8 R3 ramp after two steps", 64'(sample_out), 64'd110);

        // R6 back-to-back load of a cubic knot
        a = 0;
        while (!a) run(1, 16'd8, mk(0, 0, 0, 64'h0006_0000_0000_0000), 1, 4'd0, a);
        chk("R6 no gap, new knot shown", 64'(sample_out), 64'd0);
        chk("R6 underrun stays low", 64'(underrun), 64'd0);
        idle(4, 1, 4'd0);
        chk("R2 cubic after four steps", 64'(sample_out), 64'd24);
        idle(6, 1, 4'd0);

        // R4 zero duration handled as one step
        run(1, 16'd0, mk(16'h0777, 0, 0, 0), 0, 4'd0, a);
        chk("R4 T=0 loaded", 64'(sample_out), 64'h777);
        chk("R4 T=0 no underrun yet", 64'(underrun), 64'h0);
        idle(1, 1, 4'd0);
        chk("R4 T=0 expires after one step", 64'(underrun), 64'h1);

        // R5 stretch by 4
        run(1, 16'd10, lin, 1, 4'd2, a);
        idle(3, 1, 4'd2);
        chk("R5 no step before 4 ticks", 64'(sample_out), 64'd100);
        idle(1, 1, 4'd2);
        chk("R5 step on fourth tick", 64'(sample_out), 64'd105);

        // R9 tick gating
        idle(5, 0, 4'd2);
        chk("R9 held without ticks", 64'(sample_out), 64'd105);

        // randomised traffic
        begin
            logic [3:0] e = 4'd0;
            for (int i = 0; i < 4000; i++) begin
                logic [159:0] c;
                if (i % 300 == 0) e = 4'($urandom_range(0, 2));
                c = {$urandom, $urandom, $urandom, $urandom, $urandom};
                run(($urandom_range(0, 9) < 7), 16'($urandom_range(0, 6)), c,
                    ($urandom_range(0, 9) < 6), e, a);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule